// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the synchronous slave side of a two-wire serial memory with 256 bytes of 8 bits. The memory is modelled as an on-chip register array. A fast system clock oversamples the serial clock and data lines. From these samples the block finds Start and Stop conditions, shifts in address and data bytes, and drives acknowledge and read data through an open-drain style enable (`sda_oe` = 1 pulls the data line low).

A host writes by sending the device address, a word address and any number of data bytes. The bytes are gathered in a 16-byte page buffer. After Stop, the buffer is copied into the array during a timed programming cycle, and the block stays silent on the bus for that whole cycle. Reads come in three forms: from the current pointer, from an address set by a dummy write followed by a repeated Start, or as a stream that runs on for as long as the host keeps acknowledging.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high is a Start. From any state it aborts the transfer in progress, releases the data line (`sda_oe` = 0) and begins receiving a device address.
- R2: A rising data line while the clock line is high is a Stop. It returns the block to idle with the data line released. After reset the block is idle and `sda_oe` is 0.
- R3: The first byte after Start is acknowledged only when its upper seven bits equal binary 1010 followed by the `ADDR_LO` parameter. Bit 0 of that byte is 1 for a read and 0 for a write. An acknowledge means `sda_oe` = 1 for the whole high phase of the ninth clock. On a mismatch the block does not acknowledge and drives nothing until the next Start or Stop.
- R4: In a write, the byte after the device address loads the address pointer. Each data byte that follows is acknowledged and, once Stop is seen and the programming cycle has run, can be read back at its address.
- R5: While data bytes are being written, the pointer advances only in its low four bits. Writing past the end of a 16-byte page wraps to the start of the same page.
- R6: When more than sixteen data bytes are written, only the last sixteen are kept. Each later byte replaces the one written sixteen bytes earlier, at the same location.
- R7: A Stop that ends a write holding data starts a programming cycle of `PROG_CYCLES` clocks. During that cycle nothing is acknowledged, not even the block's own address. After it, the block acknowledges normally.
- R8: After a word address, a repeated Start and a device address with bit 0 = 1 start a random read from that address. Data is sent MSB first, and `sda_oe` = 1 during a clock high phase exactly when the bit is 0.
- R9: During a read, every byte sent advances the pointer over the whole array, wrapping from 255 to 0. A host acknowledge makes the block send the next byte.
- R10: A host not-acknowledge after a read byte makes the block release the data line. It stays released through any further clocks until the next Start or Stop.
- R11: A read with no word address starts at the pointer left by the previous operation.
- R12: A repeated Start during a write discards the data bytes of that write. No programming cycle follows, so the block acknowledges at once.
- R13: `sda_oe` changes only on the clock after a detected clock-line fall, Start or Stop. It is therefore stable through every clock high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest conditions to reach are the overflowing page write and the programming window. In the overflow case, twenty data bytes in one transfer must leave the first four slots holding the last four bytes. The programming window only exists between a Stop and the end of a long internal count. The stimulus reaches the first with a single long write followed by a full 16-byte streaming read of the page. It reaches the second by addressing the block right after the Stop of a write and expecting silence on the acknowledge clock, then addressing it again once the count has run out. A write cut short by a repeated Start is then read back at once, which shows both that its data was dropped and that no programming cycle was started.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  // Slave protocol phases
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_ACK_DEV,
    ST_WORDADDR,
    ST_ACK_WORD,
    ST_WDATA,
    ST_ACK_DATA,
    ST_RDATA,
    ST_MACK,
    ST_WAIT
  } slv_state_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  // Sync chain plus one extra stage that holds the previous sample
  logic [SYNC_STAGES:0] scl_sh;
  logic [SYNC_STAGES:0] sda_sh;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  always_comb begin
    scl_rise = scl_s & ~scl_p;
    scl_fall = ~scl_s & scl_p;
    start_ev = scl_s & scl_p & sda_p & ~sda_s;
    stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  end

endmodule

// File: rtl/i2c_page_buffer.sv
module i2c_page_buffer #(
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int PW          = 4,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          commit,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);

  localparam int SLOTS = 1 << PW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0]    slot [SLOTS];
  logic [SLOTS-1:0] valid;
  logic [AW-PW-1:0] page;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    rd_idx;

  assign rd_idx = cnt[PW-1:0];

  // Slot storage: indexed by the low address bits, so a later byte
  // aimed at the same location simply replaces the older one
  always_ff @(posedge clk) begin
    if (push && !busy) slot[push_addr[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      page      <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        if (cnt < CW'(SLOTS)) begin
          mem_we    <= valid[rd_idx];
          mem_waddr <= {page, rd_idx};
          mem_wdata <= slot[rd_idx];
        end
        if (cnt == CW'(PROG_CYCLES - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end
        cnt <= cnt + 1'b1;
      end else if (commit && (|valid)) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (clr) begin
        valid <= '0;
      end else if (push) begin
        valid[push_addr[PW-1:0]] <= 1'b1;
        page                     <= push_addr[AW-1:PW];
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_array.sv
module i2c_eeprom_array #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         AW          = 8,
  parameter int         PAGE_AW     = 4,
  parameter logic [2:0] ADDR_LO     = 3'b000,
  parameter int         PROG_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int         BW     = $clog2(DW + 1);
  localparam logic [6:0] DEV_ID = {DEV_FAMILY, ADDR_LO};

  slv_state_t    state;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] rx, tx;
  logic [AW-1:0] ptr;
  logic          rw, got_byte, host_ack;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done, buf_push, buf_clr, prog_busy, in_idle;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, rd_data;

  i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  always_comb begin
    byte_done = scl_fall && got_byte && !start_ev && !stop_ev;
    buf_push  = byte_done && (state == ST_WDATA);
    buf_clr   = start_ev || (byte_done && (state == ST_WORDADDR));
    in_idle   = (state == ST_IDLE);
  end

  i2c_page_buffer #(
    .DW(DW), .AW(AW), .PW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)
  ) u_pbuf (
    .clk       (clk),
    .rst       (rst),
    .clr       (buf_clr),
    .push      (buf_push),
    .push_addr (ptr),
    .push_data (rx),
    .commit    (stop_ev),
    .busy      (prog_busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  i2c_eeprom_array #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      got_byte <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_DEVADDR;
      bitcnt   <= '0;
      got_byte <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      got_byte <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      case (state)
        ST_DEVADDR, ST_WORDADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx     <= {rx[DW-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BW'(DW - 1)) got_byte <= 1'b1;
          end else if (byte_done) begin
            got_byte <= 1'b0;
            bitcnt   <= '0;
            if (state == ST_DEVADDR) begin
              if ((rx[DW-1:1] == DEV_ID) && !prog_busy) begin
                sda_oe <= 1'b1;
                rw     <= rx[0];
                state  <= ST_ACK_DEV;
              end else begin
                state <= ST_WAIT;
              end
            end else if (state == ST_WORDADDR) begin
              ptr    <= rx;
              sda_oe <= 1'b1;
              state  <= ST_ACK_WORD;
            end else begin
              ptr    <= {ptr[AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
              sda_oe <= 1'b1;
              state  <= ST_ACK_DATA;
            end
          end
        end
        ST_ACK_DEV: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WORDADDR;
            end
          end
        end
        ST_ACK_WORD, ST_ACK_DATA: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == BW'(DW)) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              ptr    <= ptr + 1'b1;
              state  <= ST_MACK;
            end else begin
              tx     <= {tx[DW-2:0], 1'b0};
              sda_oe <= ~tx[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              state  <= ST_RDATA;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk #(
  parameter int AW          = 8,
  parameter int PAGE_AW     = 4,
  parameter int PROG_CYCLES = 1000
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          scl_fall,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          busy,
  input logic          in_idle,
  input logic          push,
  input logic [AW-1:0] ptr
);

  localparam int RW = $clog2(PROG_CYCLES + 2);
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 1'b1;
  end

  AST_OE_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev)); // R13

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe); // R1

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !sda_oe); // R2

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe); // R7

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
    push |=> (ptr[AW-1:PAGE_AW] == $past(ptr[AW-1:PAGE_AW]))); // R5

  always_ff @(posedge clk) begin
    if (!rst) AST_PROG_BOUND: assert (busy_run <= RW'(PROG_CYCLES)); // R7
  end

endmodule

bind i2c_eeprom_slave i2c_eeprom_chk #(
  .AW(AW), .PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .busy     (prog_busy),
  .in_idle  (in_idle),
  .push     (buf_push),
  .ptr      (ptr)
);

// File: tb/i2c_eeprom_slave_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_bench;

  localparam int         HP    = 16;
  localparam int         PROG  = 1000;
  localparam logic [2:0] ALO   = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_LO(ALO), .PROG_CYCLES(PROG)) u_i2c_eeprom_slave (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int    vecs = 0;
  int    errs = 0;
  logic  chk_on = 1'b0;
  logic  exp_oe = 1'b0;
  logic  last_bit;
  string cur_tag = "";

  logic [7:0] mem_m [256];
  logic [7:0] ptr_m = 8'h00;

  // Per-clock comparison against the model's expected line drive.
  // R13: the slave output must hold through every SCL high phase.
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      vecs++;
      if (sda_oe !== exp_oe) begin
        errs++;
        $display("FAIL %s: sda_oe=%b expected %b at %0t", cur_tag, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_io(input logic b, input logic e, input string tag);
    wait_clk(2);
    sda_m = b;
    wait_clk(HP - 2);
    scl_m   = 1'b1;
    exp_oe  = e;
    cur_tag = tag;
    chk_on  = 1'b1;
    wait_clk(HP / 2);
    last_bit = sda_line;
    wait_clk(HP - HP / 2);
    chk_on = 1'b0;
    scl_m  = 1'b0;
  endtask

  task automatic start_c();
    wait_clk(2);
    sda_m = 1'b1;
    wait_clk(HP - 2);
    scl_m = 1'b1;
    wait_clk(HP / 2);
    sda_m = 1'b0;
    wait_clk(HP / 2);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wait_clk(2);
    sda_m = 1'b0;
    wait_clk(HP - 2);
    scl_m = 1'b1;
    wait_clk(HP / 2);
    sda_m = 1'b1;
    wait_clk(HP / 2);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic ack, input string tag);
    for (int i = 7; i >= 0; i--) bit_io(b[i], 1'b0, tag);
    bit_io(1'b1, ack, tag);
  endtask

  task automatic rd_byte(input logic [7:0] exp_b, input logic mack, input string tag);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, ~exp_b[i], tag);
      got[i] = last_bit;
    end
    vecs++;
    if (got !== exp_b) begin
      errs++;
      $display("FAIL %s: read byte %h expected %h", tag, got, exp_b);
    end
    bit_io(~mack, 1'b0, tag);
  endtask

  function automatic logic [7:0] dev(input logic r);
    return {4'b1010, ALO, r};
  endfunction

  task automatic do_write(input logic [7:0] wa, input int n, input logic [7:0] v0, input string tag);
    start_c();
    wr_byte(dev(1'b0), 1'b1, tag);
    wr_byte(wa, 1'b1, tag);
    ptr_m = wa;
    for (int k = 0; k < n; k++) begin
      wr_byte(v0 + 8'(k), 1'b1, tag);
      mem_m[ptr_m] = v0 + 8'(k);
      ptr_m = {ptr_m[7:4], ptr_m[3:0] + 4'd1};
    end
    stop_c();
  endtask

  task automatic seq_read(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      rd_byte(mem_m[ptr_m], (k < n - 1), tag);
      ptr_m = ptr_m + 8'd1;
    end
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string tag);
    start_c();
    wr_byte(dev(1'b0), 1'b1, tag);
    wr_byte(wa, 1'b1, tag);
    ptr_m = wa;
    start_c();
    wr_byte(dev(1'b1), 1'b1, tag);
    seq_read(n, tag);
    stop_c();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);
    vecs++;
    if (sda_oe !== 1'b0) begin
      errs++;
      $display("FAIL R2 reset: sda_oe=%b expected 0", sda_oe);
    end

    // R3: foreign address, then more clocks that must stay undriven
    start_c();
    wr_byte({4'b1010, ~ALO, 1'b0}, 1'b0, "R3 mismatch");
    wr_byte(8'h00, 1'b0, "R3 ignored");
    stop_c();

    // R4: single byte write, then R7 busy probe
    do_write(8'h10, 1, 8'hA5, "R4 byte write");
    start_c();
    wr_byte(dev(1'b0), 1'b0, "R7 busy no ack");
    stop_c();
    wait_clk(PROG + 40);
    rand_read(8'h10, 1, "R8 random read");

    // R5: page wrap from 0x2E
    do_write(8'h2E, 3, 8'h31, "R5 page write");
    wait_clk(PROG + 40);
    rand_read(8'h2E, 3, "R5 read across page end");
    rand_read(8'h20, 1, "R5 wrapped byte");

    // R6: twenty bytes into one page
    do_write(8'h40, 20, 8'hC0, "R6 overflow write");
    wait_clk(PROG + 40);
    rand_read(8'h40, 16, "R6 last sixteen kept");

    // R9: sequential read over the top of the array
    rand_read(8'hFF, 2, "R9 wrap 255 to 0");

    // R11: current-address read, then R10 release after host NACK
    start_c();
    wr_byte(dev(1'b1), 1'b1, "R11 current read");
    seq_read(1, "R11 current read");
    bit_io(1'b1, 1'b0, "R10 released after nack");
    bit_io(1'b1, 1'b0, "R10 released after nack");
    stop_c();

    // R12: write cut by repeated start, then R1 restart into a read
    start_c();
    wr_byte(dev(1'b0), 1'b1, "R12 write");
    wr_byte(8'h60, 1'b1, "R12 write");
    wr_byte(8'h77, 1'b1, "R12 write");
    ptr_m = 8'h61;
    start_c();
    wr_byte(dev(1'b1), 1'b1, "R1 restart read");
    seq_read(1, "R1 restart read");
    stop_c();
    rand_read(8'h60, 1, "R12 data discarded");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule